// File: doc/BRIEF.md
# Privilege-aware local interrupt selector

This block decides which local interrupt a hart should take in the coming cycle. It takes four inputs: the vector of pending interrupt lines, the per-line enable vector, the delegation mask, and the hart's current privilege level with the two global interrupt-enable bits for the machine and supervisor levels. A pending and enabled line survives only if the level it is routed to accepts interrupts at the current privilege. Of the surviving lines, the one with the lowest index wins.

The result is registered. One cycle after the inputs are presented, the block drives three outputs: a take flag, the winning index, and a trap-cause word. The cause word holds the index in its low bits and an interrupt marker in its most-significant bit. Trap-entry logic uses the take flag to start a trap, and writes the cause word into its cause register unchanged.

Top module: `irq_pick`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, the next values of `take_o`, `idx_o` and `cause_o` are all zero.
- R2: A line is a candidate only when both its `pend_i` bit and its `en_i` bit are 1. A line whose enable bit is 0 is never selected.
- R3: A candidate whose `deleg_i` bit is 0 is routed to machine level. Privilege is encoded as user=0, supervisor=1, machine=3, and values are compared unsigned. Such a candidate survives when `priv_i` < 3, or when `priv_i` = 3 and `mie_i` = 1.
- R4: A candidate whose `deleg_i` bit is 1 is routed to supervisor level. It survives when `priv_i` < 1, or when `priv_i` = 1 and `sie_i` = 1. At `priv_i` = 3 no delegated line is ever taken.
- R5: When at least one line survives, `idx_o` is the lowest index among the surviving lines and `take_o` is 1.
- R6: When no line survives, `take_o`, `idx_o` and `cause_o` are all 0.
- R7: When `take_o` is 1, `cause_o` has its most-significant bit set, holds `idx_o` in its low bits, and has every other bit zero.
- R8: The outputs after a rising edge reflect the inputs sampled at that edge. Latency is exactly one cycle.
- R9: The unused privilege code 2 follows the unsigned comparisons. Lines routed to machine level survive regardless of `mie_i`, and lines routed to supervisor level never survive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | NIRQ (64) | Pending interrupt lines |
| en_i | input | NIRQ (64) | Per-line enable |
| deleg_i | input | NIRQ (64) | Delegation mask, 1 = routed to supervisor |
| priv_i | input | 2 | Current privilege level |
| mie_i | input | 1 | Machine-level global interrupt enable |
| sie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| idx_o | output | $clog2(NIRQ) (6) | Index of the selected line |
| cause_o | output | XLEN (64) | Trap-cause word: interrupt marker in the MSB, index in the low bits |

## Verification
The bench aims at each corner case below. What a faulty design would show is given for each one:
- All-zero inputs. A faulty design would raise a spurious take.
- Only the top line pending. A faulty design would truncate the index.
- A line pending but disabled. A faulty design would select it anyway.
- Every privilege level, including the unused code 2, crossed with every setting of the two global enables. A faulty design would mishandle one of the two routing rules at the boundary where the current privilege equals the target level.
- Several lines set at once. This exposes a priority encoder that picks the highest index rather than the lowest.
- The exact cause word. This exposes a misplaced interrupt marker or stray high bits.
- A random stream, compared every cycle. This catches a design that adds or drops a pipeline stage.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  // A level accepts interrupts when the hart runs below it, or at it with
  // that level's global enable set.
  function automatic logic lvl_open(input logic [1:0] cur,
                                    input logic [1:0] target,
                                    input logic       gie);
    return (cur < target) || ((cur == target) && gie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pick_pkg::*;
#(
  parameter int NIRQ = 64
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            mie,
  input  logic            sie,
  output logic            m_open,
  output logic            s_open,
  output logic [NIRQ-1:0] gated
);

  logic [NIRQ-1:0] cand;

  assign m_open = lvl_open(priv, PRIV_M, mie);
  assign s_open = lvl_open(priv, PRIV_S, sie);
  assign cand   = pend & en;

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    assign gated[i] = cand[i] & (deleg[i] ? s_open : m_open);
  end

endmodule

// File: rtl/irq_lsb.sv
module irq_lsb #(
  parameter int NIRQ = 64,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0] vec,
  output logic            hit,
  output logic [IDXW-1:0] idx
);

  // Scan from the top down so the lowest set bit is written last.
  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end

  assign hit = |vec;

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pick_pkg::*;
#(
  parameter int NIRQ = 64,
  parameter int XLEN = 64,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic            take_o,
  output logic [IDXW-1:0] idx_o,
  output logic [XLEN-1:0] cause_o
);

  function automatic logic [XLEN-1:0] make_cause(input logic [IDXW-1:0] idx);
    logic [XLEN-1:0] c;
    c = XLEN'(idx);
    c[XLEN-1] = 1'b1;
    return c;
  endfunction

  logic [NIRQ-1:0] gated_w;
  logic            m_open_w;
  logic            s_open_w;
  logic            hit_w;
  logic [IDXW-1:0] idx_w;

  irq_gate #(.NIRQ(NIRQ)) u_gate (
    .pend   (pend_i),
    .en     (en_i),
    .deleg  (deleg_i),
    .priv   (priv_i),
    .mie    (mie_i),
    .sie    (sie_i),
    .m_open (m_open_w),
    .s_open (s_open_w),
    .gated  (gated_w)
  );

  irq_lsb #(.NIRQ(NIRQ)) u_lsb (
    .vec (gated_w),
    .hit (hit_w),
    .idx (idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      idx_o   <= '0;
      cause_o <= '0;
    end else begin
      take_o  <= hit_w;
      idx_o   <= hit_w ? idx_w : '0;
      cause_o <= hit_w ? make_cause(idx_w) : '0;
    end
  end

endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk #(
  parameter int NIRQ = 64,
  parameter int XLEN = 64,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NIRQ-1:0] pend_i,
  input logic [NIRQ-1:0] en_i,
  input logic [NIRQ-1:0] deleg_i,
  input logic [1:0]      priv_i,
  input logic            mie_i,
  input logic            take_o,
  input logic [IDXW-1:0] idx_o,
  input logic [XLEN-1:0] cause_o,
  input logic [NIRQ-1:0] gated_w
);

  localparam logic [NIRQ-1:0] ONE = NIRQ'(1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!take_o && idx_o == '0 && cause_o == '0));

  // R2
  cand_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (gated_w & ~(pend_i & en_i)) == '0);

  // R3
  m_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_i == 2'd3 && !mie_i) |-> ((gated_w & ~deleg_i) == '0));

  // R4
  s_closed_at_m_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_i == 2'd3) |-> ((gated_w & deleg_i) == '0));

  // R9
  priv_two_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_i == 2'd2) |-> (gated_w == (pend_i & en_i & ~deleg_i)));

  // R8
  take_latency_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (take_o == $past(|gated_w)));

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!take_o || ((($past(gated_w) >> idx_o) & ONE) == ONE &&
                          ($past(gated_w) & ((ONE << idx_o) - ONE)) == '0)));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (idx_o == '0 && cause_o == '0));

  // R7
  cause_form_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cause_o == ({1'b1, {(XLEN-1){1'b0}}} | XLEN'(idx_o))));

endmodule

bind irq_pick irq_pick_chk #(.NIRQ(NIRQ), .XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pend_i  (pend_i),
  .en_i    (en_i),
  .deleg_i (deleg_i),
  .priv_i  (priv_i),
  .mie_i   (mie_i),
  .take_o  (take_o),
  .idx_o   (idx_o),
  .cause_o (cause_o),
  .gated_w (gated_w)
);

// File: tb/irq_pick_test.sv
`timescale 1ns/1ps
module irq_pick_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pend_i = '0, en_i = '0, deleg_i = '0;
  logic [1:0]  priv_i = 2'd0;
  logic        mie_i = 1'b0, sie_i = 1'b0;
  logic        take_o;
  logic [5:0]  idx_o;
  logic [63:0] cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_pick uut (
    .clk(clk), .rst(rst), .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i),
    .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i),
    .take_o(take_o), .idx_o(idx_o), .cause_o(cause_o)
  );

  // Behavioural reference: walk the lines upward and stop at the first taker.
  bit          e_take;
  int          e_idx;
  logic [63:0] e_cause;
  string       e_tag;

  task automatic predict();
    int p;
    bit m_ok, s_ok;
    p = int'(priv_i);
    m_ok = (p < 3) || (p == 3 && mie_i);
    s_ok = (p < 1) || (p == 1 && sie_i);
    e_take = 0; e_idx = 0; e_cause = 64'd0;
    for (int i = 0; i < 64; i++) begin
      if (pend_i[i] && en_i[i] && (deleg_i[i] ? s_ok : m_ok)) begin
        e_take = 1; e_idx = i;
        e_cause = (64'd1 << 63) + 64'(i);
        break;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (take_o !== e_take || int'(idx_o) != e_idx || cause_o !== e_cause) begin
      errors++;
      $display("FAIL %s: take=%0b idx=%0d cause=%h expected take=%0b idx=%0d cause=%h",
               e_tag, take_o, idx_o, cause_o, e_take, e_idx, e_cause);
    end
  endtask

  // Drive at the falling edge; the result appears after the next rising edge
  // and is compared at the falling edge after that.
  task automatic step(input logic [63:0] p, input logic [63:0] e,
                      input logic [63:0] d, input logic [1:0] pr,
                      input logic m, input logic s, input string tag);
    pend_i = p; en_i = e; deleg_i = d; priv_i = pr; mie_i = m; sie_i = s;
    predict();
    e_tag = tag;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset with live inputs must still give zero outputs
    pend_i = '1; en_i = '1;
    repeat (3) @(negedge clk);
    e_take = 0; e_idx = 0; e_cause = '0; e_tag = "R1";
    compare();
    rst = 1'b0;
    pend_i = '0; en_i = '0;

    // R6: all-zero input
    step('0, '0, '0, 2'd3, 1, 1, "R6");
    step('1, '0, '0, 2'd0, 1, 1, "R6");
    // R2: pending but disabled, or enabled but not pending
    step(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0020, '0, 2'd0, 0, 0, "R2");
    step(64'h1, 64'h2, '0, 2'd0, 0, 0, "R2");
    // R5/R7: only the top line
    step(64'h8000_0000_0000_0000, '1, '0, 2'd0, 0, 0, "R7");
    // R5: lowest of several
    step(64'h8000_0100_0004_0800, '1, '0, 2'd1, 0, 0, "R5");
    step(64'hFFFF_FFFF_FFFF_FFFE, '1, '0, 2'd3, 1, 0, "R5");
    // R3: machine-routed across all privileges and enables
    for (int pr = 0; pr < 4; pr++)
      for (int m = 0; m < 2; m++)
        step(64'h0000_0000_0000_0880, '1, '0, 2'(pr), 1'(m), 1'b1,
             pr == 2 ? "R9" : "R3");
    // R4: supervisor-routed across all privileges and enables
    for (int pr = 0; pr < 4; pr++)
      for (int s = 0; s < 2; s++)
        step(64'h0000_0200_0000_0000, '1, 64'h0000_0200_0000_0000, 2'(pr),
             1'b1, 1'(s), pr == 2 ? "R9" : "R4");
    // R4: at supervisor with sie off, delegated low line loses to machine line
    step(64'h0000_0000_0000_0009, '1, 64'h1, 2'd1, 0, 0, "R4");
    step(64'h0000_0000_0000_0009, '1, 64'h1, 2'd1, 0, 1, "R4");
    // R8: back-to-back changes, each compared one cycle later
    step(64'h10, '1, '0, 2'd0, 0, 0, "R8");
    step('0, '1, '0, 2'd0, 0, 0, "R8");
    step(64'h4, '1, '0, 2'd0, 0, 0, "R8");
    // Random stream with sparse and dense patterns
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] p;
      p = (n % 3 == 0) ? (r64() & r64() & r64() & r64()) : r64();
      step(p, r64() | r64(), r64(), 2'($urandom_range(0, 3)),
           1'($urandom), 1'($urandom), "R5");
    end
    // R1: reset in mid-stream
    pend_i = '1; en_i = '1; priv_i = 2'd0;
    rst = 1'b1;
    @(negedge clk);
    e_take = 0; e_idx = 0; e_cause = '0; e_tag = "R1";
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule